// File: doc/BRIEF.md
# Staged Coefficient Commit Buffer

This block sits between a control-port write bus and the single write port of a DSP core's parameter RAM. Software stages a related group of coefficients, such as the five values of one biquad section, into a small bank of slots. Each slot holds a target RAM address, a 28-bit value and a valid flag. A later command arms a commit. The commit then copies every valid slot into the live parameter RAM in the first audio frame that follows. The DSP program keeps running throughout, and the core's own RAM accesses always take precedence over the commit.

The block also holds a core control register. One bit of this register halts the core so that large images can be written straight into parameter RAM. Clearing the bit lets the core run again. A second bit of the same register arms the commit and reads as cleared once the copy has begun.

The sequencer has three states. IDLE leaves on an arm request and goes to ARMED. ARMED leaves on a frame-start strobe and goes to COPY, with the slot index set to zero. COPY steps through the slots in ascending order. It advances past an empty slot at once, and past a valid slot once that slot has been written. It stays on a valid slot for as long as the core holds the port. When it advances past the last slot, it clears all valid flags and returns to IDLE. Any undefined encoding goes back to IDLE.

Top module: `safeload_buffer`

## Requirements
- R1: After reset, busy, core_halt and ram_we are 0 and every slot is empty.
- R2: A write to address 2064+k (k = 0..4) stores the value in slot k and marks it valid. A write to 2069+k stores bits [9:0] as slot k's target address. Both kinds of write are ignored while busy is 1.
- R3: A write to address 2076 with bit 1 set arms the commit while idle, and busy reads 1 from the next cycle on.
- R4: An armed commit waits for the first frame_start, then starts the copy at slot 0. The arm bit is consumed, and frame_start has no effect when the block is not armed.
- R5: During the copy, slots are visited in ascending index order, one slot per cycle. A valid slot puts its address and value on the RAM port. An empty slot is skipped without a write.
- R6: ram_we is never 1 in a cycle with core_ram_req high. A valid slot blocked by the core is held until a free cycle.
- R7: busy stays 1 until the cycle after the last slot is visited. All valid flags are then cleared, so a commit armed with nothing restaged writes nothing.
- R8: Bit 0 of a write to address 2076 sets core_halt from the next cycle on. Clearing it releases the halt.
- R9: A write to an address below 1024 goes straight to the RAM port in the same cycle only when core_halt is 1, core_ram_req is 0 and no commit write happens in that cycle. Otherwise it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cp_wr_en | input | 1 | Control-port write strobe |
| cp_addr | input | 12 | Control-port write address |
| cp_wdata | input | 28 | Control-port write value |
| frame_start | input | 1 | One-cycle audio frame strobe |
| core_ram_req | input | 1 | Core uses the parameter RAM port this cycle |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_waddr | output | 10 | Parameter RAM write address |
| ram_wdata | output | 28 | Parameter RAM write value |
| busy | output | 1 | Commit armed or in progress |
| core_halt | output | 1 | Core halt request |

## Verification
The main collision is between a core RAM access and a valid slot waiting to be committed. The bench raises core_ram_req on the exact cycles in which the copy stands on a valid slot. Its cycle-by-cycle model then expects no write, the slot held, and the write issued in the first free cycle. A second collision occurs when a direct write arrives while the core is halted in a cycle that also carries a commit write. The model expects the direct write to be dropped in that cycle and to pass through in a later cycle that visits an empty slot.

// File: rtl/sl_pkg.sv
package sl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COPY  = 2'd2
    } sl_state_e;

    localparam int HALT_BIT = 0;
    localparam int ARM_BIT  = 1;
endpackage

// File: rtl/sl_ctrl_regs.sv
module sl_ctrl_regs #(
    parameter int ADDR_W    = 12,
    parameter int RAM_AW    = 10,
    parameter int N_SLOTS   = 5,
    parameter int SW        = 3,
    parameter int CTRL_ADDR = 2076,
    parameter int DATA_BASE = 2064,
    parameter int ADR_BASE  = 2069
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_wr_en,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [1:0]        ctrl_bits,
    input  logic              lock,
    output logic              slot_data_we,
    output logic              slot_addr_we,
    output logic [SW-1:0]     slot_idx,
    output logic              arm_req,
    output logic              param_we,
    output logic              halt
);
    logic [N_SLOTS-1:0] data_hit;
    logic [N_SLOTS-1:0] adr_hit;
    logic               ctrl_hit;

    genvar k;
    generate
        for (k = 0; k < N_SLOTS; k++) begin : g_hit
            assign data_hit[k] = (cp_addr == ADDR_W'(DATA_BASE + k));
            assign adr_hit[k]  = (cp_addr == ADDR_W'(ADR_BASE + k));
        end
    endgenerate

    assign ctrl_hit = (cp_addr == ADDR_W'(CTRL_ADDR));

    always_comb begin
        slot_idx = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (data_hit[i] || adr_hit[i]) slot_idx = SW'(i);
        end
    end

    assign slot_data_we = cp_wr_en && !lock && (|data_hit);
    assign slot_addr_we = cp_wr_en && !lock && (|adr_hit);
    assign arm_req      = cp_wr_en && ctrl_hit && ctrl_bits[sl_pkg::ARM_BIT];
    assign param_we     = cp_wr_en && (cp_addr[ADDR_W-1:RAM_AW] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt <= 1'b0;
        end else if (cp_wr_en && ctrl_hit) begin
            halt <= ctrl_bits[sl_pkg::HALT_BIT];
        end
    end
endmodule

// File: rtl/sl_slot_bank.sv
module sl_slot_bank #(
    parameter int N_SLOTS = 5,
    parameter int DATA_W  = 28,
    parameter int RAM_AW  = 10,
    parameter int SW      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic              addr_we,
    input  logic [SW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              clear_all,
    input  logic [SW-1:0]     rd_idx,
    output logic              rd_valid,
    output logic [RAM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [N_SLOTS-1:0] valid_q;
    logic [RAM_AW-1:0]  addr_q [N_SLOTS];
    logic [DATA_W-1:0]  data_q [N_SLOTS];

    genvar k;
    generate
        for (k = 0; k < N_SLOTS; k++) begin : g_slot
            logic sel;
            assign sel = (wr_idx == SW'(k));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q[k] <= 1'b0;
                    data_q[k]  <= '0;
                    addr_q[k]  <= '0;
                end else begin
                    if (clear_all) begin
                        valid_q[k] <= 1'b0;
                    end else if (data_we && sel) begin
                        valid_q[k] <= 1'b1;
                    end
                    if (data_we && sel) data_q[k] <= wr_val;
                    if (addr_we && sel) addr_q[k] <= wr_val[RAM_AW-1:0];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_valid = 1'b0;
        rd_addr  = '0;
        rd_data  = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (rd_idx == SW'(i)) begin
                rd_valid = valid_q[i];
                rd_addr  = addr_q[i];
                rd_data  = data_q[i];
            end
        end
    end
endmodule

// File: rtl/sl_copy_fsm.sv
module sl_copy_fsm
    import sl_pkg::*;
#(
    parameter int N_SLOTS = 5,
    parameter int SW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_req,
    input  logic          frame_start,
    input  logic          core_req,
    input  logic          slot_valid,
    output logic [SW-1:0] idx,
    output logic          sl_we,
    output logic          clear_all,
    output logic          busy
);
    localparam logic [SW-1:0] LAST = SW'(N_SLOTS - 1);

    sl_state_e     state_q, state_d;
    logic [SW-1:0] idx_q, idx_d;
    logic          advance;
    logic          at_last;

    assign at_last = (idx_q == LAST);
    assign advance = (state_q == ST_COPY) && (!slot_valid || !core_req);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_req) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (frame_start) begin
                    state_d = ST_COPY;
                    idx_d   = '0;
                end
            end
            ST_COPY: begin
                if (advance) begin
                    if (at_last) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + SW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        idx       = idx_q;
        busy      = (state_q != ST_IDLE);
        sl_we     = (state_q == ST_COPY) && slot_valid && !core_req;
        clear_all = advance && at_last;
    end
endmodule

// File: rtl/sl_port_mux.sv
module sl_port_mux #(
    parameter int DATA_W = 28,
    parameter int RAM_AW = 10
) (
    input  logic              sl_we,
    input  logic [RAM_AW-1:0] sl_addr,
    input  logic [DATA_W-1:0] sl_data,
    input  logic              param_we,
    input  logic              halt,
    input  logic              core_req,
    input  logic [RAM_AW-1:0] cp_addr,
    input  logic [DATA_W-1:0] cp_data,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata
);
    logic direct_ok;

    always_comb begin
        direct_ok = param_we && halt && !core_req && !sl_we;
        ram_we    = sl_we || direct_ok;
        ram_waddr = sl_we ? sl_addr : cp_addr;
        ram_wdata = sl_we ? sl_data : cp_data;
    end
endmodule

// File: rtl/safeload_buffer.sv
module safeload_buffer #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 28,
    parameter int RAM_AW    = 10,
    parameter int N_SLOTS   = 5,
    parameter int CTRL_ADDR = 2076,
    parameter int DATA_BASE = 2064,
    parameter int ADR_BASE  = 2069
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_wr_en,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [DATA_W-1:0] cp_wdata,
    input  logic              frame_start,
    input  logic              core_ram_req,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              busy,
    output logic              core_halt
);
    localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    logic              slot_data_we, slot_addr_we, arm_req, param_we;
    logic [SW-1:0]     slot_idx, copy_idx;
    logic              slot_valid, sl_we, clear_all;
    logic [RAM_AW-1:0] slot_addr;
    logic [DATA_W-1:0] slot_data;

    sl_ctrl_regs #(
        .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .N_SLOTS(N_SLOTS), .SW(SW),
        .CTRL_ADDR(CTRL_ADDR), .DATA_BASE(DATA_BASE), .ADR_BASE(ADR_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cp_wr_en(cp_wr_en), .cp_addr(cp_addr),
        .ctrl_bits(cp_wdata[1:0]), .lock(busy),
        .slot_data_we(slot_data_we), .slot_addr_we(slot_addr_we),
        .slot_idx(slot_idx), .arm_req(arm_req), .param_we(param_we),
        .halt(core_halt)
    );

    sl_slot_bank #(
        .N_SLOTS(N_SLOTS), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .SW(SW)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .data_we(slot_data_we), .addr_we(slot_addr_we),
        .wr_idx(slot_idx), .wr_val(cp_wdata), .clear_all(clear_all),
        .rd_idx(copy_idx), .rd_valid(slot_valid), .rd_addr(slot_addr),
        .rd_data(slot_data)
    );

    sl_copy_fsm #(
        .N_SLOTS(N_SLOTS), .SW(SW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .frame_start(frame_start),
        .core_req(core_ram_req), .slot_valid(slot_valid), .idx(copy_idx),
        .sl_we(sl_we), .clear_all(clear_all), .busy(busy)
    );

    sl_port_mux #(
        .DATA_W(DATA_W), .RAM_AW(RAM_AW)
    ) u_mux (
        .sl_we(sl_we), .sl_addr(slot_addr), .sl_data(slot_data),
        .param_we(param_we), .halt(core_halt), .core_req(core_ram_req),
        .cp_addr(cp_addr[RAM_AW-1:0]), .cp_data(cp_wdata),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
    );
endmodule

// File: rtl/safeload_checker.sv
module safeload_checker #(
    parameter int ADDR_W    = 12,
    parameter int CTRL_ADDR = 2076
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cp_wr_en,
    input logic [ADDR_W-1:0] cp_addr,
    input logic              halt_bit,
    input logic              core_ram_req,
    input logic              ram_we,
    input logic              busy,
    input logic              core_halt
);
    logic ctrl_wr;
    assign ctrl_wr = cp_wr_en && (cp_addr == ADDR_W'(CTRL_ADDR));

    assert_core_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_ram_req |-> !ram_we);

    assert_write_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !core_halt) |-> busy);

    assert_arm_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_wr));

    assert_halt_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (core_halt == $past(halt_bit)));

    assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(core_halt));
endmodule

bind safeload_buffer safeload_checker #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cp_wr_en(cp_wr_en), .cp_addr(cp_addr),
    .halt_bit(cp_wdata[0]), .core_ram_req(core_ram_req), .ram_we(ram_we),
    .busy(busy), .core_halt(core_halt)
);

// File: tb/tb_safeload_buffer.sv
module tb_safeload_buffer;
    localparam int N     = 5;
    localparam int CTRL  = 2076;
    localparam int DBASE = 2064;
    localparam int ABASE = 2069;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cp_wr_en;
    logic [11:0] cp_addr;
    logic [27:0] cp_wdata;
    logic        frame_start;
    logic        core_ram_req;
    logic        ram_we;
    logic [9:0]  ram_waddr;
    logic [27:0] ram_wdata;
    logic        busy;
    logic        core_halt;

    always #10 clk = ~clk;

    safeload_buffer dut (
        .clk(clk), .rst_n(rst_n), .cp_wr_en(cp_wr_en), .cp_addr(cp_addr),
        .cp_wdata(cp_wdata), .frame_start(frame_start), .core_ram_req(core_ram_req),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .busy(busy), .core_halt(core_halt)
    );

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural model: 0 idle, 1 armed, 2 copying
    int          m_st, m_idx;
    bit          m_halt;
    bit          m_val  [N];
    int          m_addr [N];
    logic [27:0] m_data [N];
    int          writes_seen;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        bit e_sl, e_dir, lock;
        #5;
        e_sl  = (m_st == 2) && m_val[m_idx] && !core_ram_req;
        e_dir = cp_wr_en && (cp_addr < 1024) && m_halt && !core_ram_req && !e_sl;
        chk(tag, "ram_we", 32'(ram_we), 32'(e_sl || e_dir));
        if (e_sl) begin
            chk(tag, "ram_waddr", 32'(ram_waddr), 32'(m_addr[m_idx]));
            chk(tag, "ram_wdata", 32'(ram_wdata), 32'(m_data[m_idx]));
        end else if (e_dir) begin
            chk(tag, "ram_waddr", 32'(ram_waddr), 32'(cp_addr[9:0]));
            chk(tag, "ram_wdata", 32'(ram_wdata), 32'(cp_wdata));
        end
        if (ram_we) writes_seen++;
        chk(tag, "busy", 32'(busy), 32'(m_st != 0));
        chk(tag, "core_halt", 32'(core_halt), 32'(m_halt));
        @(posedge clk);
        lock = (m_st != 0);
        if (m_st == 2) begin
            if (!m_val[m_idx] || !core_ram_req) begin
                if (m_idx == N - 1) begin
                    m_st = 0;
                    m_idx = 0;
                    for (int i = 0; i < N; i++) m_val[i] = 0;
                end else begin
                    m_idx++;
                end
            end
        end else if (m_st == 1 && frame_start) begin
            m_st = 2;
            m_idx = 0;
        end
        if (cp_wr_en) begin
            if (cp_addr == CTRL) begin
                m_halt = cp_wdata[0];
                if (!lock && cp_wdata[1]) m_st = 1;
            end else if (!lock && cp_addr >= DBASE && cp_addr < DBASE + N) begin
                m_data[cp_addr - DBASE] = cp_wdata;
                m_val[cp_addr - DBASE]  = 1;
            end else if (!lock && cp_addr >= ABASE && cp_addr < ABASE + N) begin
                m_addr[cp_addr - ABASE] = int'(cp_wdata[9:0]);
            end
        end
        @(negedge clk);
    endtask

    task automatic cpw(int a, int d, string tag);
        cp_wr_en = 1'b1;
        cp_addr  = 12'(a);
        cp_wdata = 28'(d);
        step(tag);
        cp_wr_en = 1'b0;
        cp_addr  = '0;
        cp_wdata = '0;
    endtask

    task automatic stage(int k, int a, int d, string tag);
        cpw(ABASE + k, a, tag);
        cpw(DBASE + k, d, tag);
    endtask

    task automatic frame(string tag);
        frame_start = 1'b1;
        step(tag);
        frame_start = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        m_st = 0; m_idx = 0; m_halt = 0; writes_seen = 0;
        for (int i = 0; i < N; i++) begin
            m_val[i] = 0; m_addr[i] = 0; m_data[i] = '0;
        end
        rst_n = 1'b0; cp_wr_en = 0; cp_addr = '0; cp_wdata = '0;
        frame_start = 0; core_ram_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state; frame_start while idle is ignored (R4)
        step("R1");
        frame("R4");
        step("R1");

        // R2 staging all five slots, R3 arm, R4 wait for frame, R5 full copy
        for (int k = 0; k < N; k++) stage(k, 16 + k * 3, 28'h0A00000 + k, "R2");
        cpw(CTRL, 2, "R3");
        step("R4");
        step("R4");
        frame("R4");
        for (int k = 0; k < N; k++) step("R5");
        step("R7");

        // R7 valid flags cleared: empty commit writes nothing
        writes_seen = 0;
        cpw(CTRL, 2, "R7");
        frame("R7");
        for (int k = 0; k < N + 1; k++) step("R7");
        chk("R7", "empty_commit_writes", 32'(writes_seen), 32'd0);

        // R5 sparse slots, R6 core holds the port
        stage(1, 300, 28'h1234567, "R2");
        stage(3, 700, 28'h7654321, "R2");
        cpw(CTRL, 2, "R3");
        frame("R4");
        core_ram_req = 1; step("R5");   // slot 0 empty, skipped despite core
        step("R6");                     // slot 1 held
        step("R6");
        core_ram_req = 0; step("R6");   // slot 1 written
        core_ram_req = 1; step("R5");   // slot 2 empty
        step("R6");                     // slot 3 held
        core_ram_req = 0; step("R6");
        step("R5");                     // slot 4 empty
        step("R7");

        // R2 writes ignored while busy: armed commit keeps old value
        stage(2, 55, 28'h0000111, "R2");
        cpw(CTRL, 2, "R3");
        cpw(DBASE + 2, 28'h0FFFFFF, "R2");
        cpw(ABASE + 2, 999, "R2");
        frame("R4");
        for (int k = 0; k < N + 1; k++) step("R2");

        // R8 halt; R9 direct writes
        cpw(100, 28'h0000ABC, "R9");    // not halted: dropped
        cpw(CTRL, 1, "R8");
        step("R8");
        cpw(101, 28'h0000DEF, "R9");    // halted, port free: passes
        core_ram_req = 1;
        cpw(102, 28'h0000BAD, "R9");    // core owns port: dropped
        core_ram_req = 0;
        cpw(2000, 28'h0000777, "R9");   // outside RAM range: dropped

        // R9 collision with commit write while halted (arm keeps halt set)
        stage(0, 40, 28'h0C0FFEE, "R2");
        cpw(CTRL, 3, "R3");
        frame("R4");
        cpw(200, 28'h0000001, "R9");    // slot 0 write wins, direct dropped
        cpw(201, 28'h0000002, "R9");    // slot 1 empty, direct passes
        for (int k = 0; k < N - 1; k++) step("R5");

        // R8 release the halt
        cpw(CTRL, 0, "R8");
        step("R8");
        cpw(150, 28'h0000003, "R9");    // released: dropped

        finished = 1;
        summary();
        $finish;
    end
endmodule